// File: doc/BRIEF.md
# Peak-Windowing Crest Factor Reducer

This block lowers the peak-to-average power ratio of a complex baseband transmit stream. It takes one signed I/Q pair per cycle in which the input valid is high. It tests each sample's power against a programmable limit. For every sample that exceeds the limit it forms a clipping weight, which is the fraction of the amplitude that has to be removed. Each weight is spread over its neighbours with a loadable smoothing window. A delayed copy of the stream is then scaled down by the smoothed weight. A programmable digital gain follows the scaling.

Configuration is held in a small register file. It stores the window coefficients, the window order, the threshold, the output gain and two mode flags: pass-through, and the doubled-rate mode that halves the largest usable order. Every register can be read back. A transmitter with two paths uses one instance per path. Configuration is changed while the stream is idle.

Top module: `peakwin_cfr`

## Requirements
- R1: An input sample taken while `in_valid` is high appears at the output MAX_ORD/2+7 cycles later (27 cycles by default), with `out_valid` high. A sample taken while `in_valid` is low produces `out_valid` low and both outputs zero.
- R2: A threshold register value of 32768 (1.0 in unsigned Q1.15) or more disables clipping. Every sample then leaves as the gain stage alone gives it.
- R3: The gain register is unsigned Q2.14, with 16384 = 1.0. Each output component is floor(x·gain/16384) saturated to [-32768, 32767].
- R4: Bit 0 of the flags register selects pass-through. In that mode the output equals the input exactly, with the R1 latency, and neither clipping nor gain is applied.
- R5: A sample whose I²+Q² exceeds T², where T is the threshold value, is clipped. An isolated peak, seen through a window coefficient of 1.0, leaves with a magnitude between 0.9·T and 1.08·T.
- R6: A sample that no peak's window reaches passes through the gain stage unchanged.
- R7: With effective order N, a peak at sample k scales sample k+t using coefficient index j = floor(N/2)+t, for j from 0 to N. A neighbour whose coefficient is 0 is unaffected, and so is a sample outside that span.
- R8: The effective order is 1 when the order register holds 0. It is capped at MAX_ORD (40) in base mode and at MAX_ORD/2 (20) when bit 1 of the flags register (doubled-rate mode) is set.
- R9: The register map places coefficient j at address j (0 to 40), the order at 0x40, the threshold at 0x41, the gain at 0x42 and the flags at 0x43. Reset values are: coefficients 0, order 1, threshold 32768, gain 16384, flags 0. A read returns the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr`, combinational |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |

## Verification
The embedded checks assume the following about the inputs:
- Window coefficients lie between 0 and 1.0.
- Configuration changes only while no samples are in flight.
- The effective order the shift logic sees is already clamped.

The stimulus meets these conditions. It writes every register between bursts, and it follows each burst with enough idle cycles to empty the weight delay line. It also keeps peaks isolated, so that one peak's window never overlaps another's and the R5 magnitude bound can be checked.

// File: rtl/peakwin_pkg.sv
package peakwin_pkg;

    localparam int SW       = 16;
    localparam int CW       = 16;
    localparam int GW       = 16;
    localparam int QF       = 15;
    localparam int GFRAC    = 14;
    localparam int AW       = 7;
    localparam int LUT_BITS = 5;
    localparam int LUT_N    = 1 << LUT_BITS;

    localparam logic [CW-1:0] ONE_Q15  = CW'(1 << QF);
    localparam logic [GW-1:0] GAIN_ONE = GW'(1 << GFRAC);

    localparam logic [AW-1:0] A_ORDER = 7'h40;
    localparam logic [AW-1:0] A_THR   = 7'h41;
    localparam logic [AW-1:0] A_GAIN  = 7'h42;
    localparam logic [AW-1:0] A_FLAGS = 7'h43;

    typedef struct packed {
        logic                 valid;
        logic signed [SW-1:0] i;
        logic signed [SW-1:0] q;
    } iq_t;

    localparam int IQW = $bits(iq_t);

    function automatic logic [3:0] lead_one(input logic [15:0] v);
        logic [3:0] p;
        p = '0;
        for (int b = 0; b < 16; b++) begin
            if (v[b]) p = 4'(b);
        end
        return p;
    endfunction

    function automatic logic signed [SW-1:0] sat_s16(input logic signed [33:0] v);
        if (v > 34'sd32767)       return 16'sh7fff;
        else if (v < -34'sd32768) return 16'sh8000;
        else                      return SW'(v);
    endfunction

    function automatic logic [16:0] abs17(input logic signed [SW-1:0] x);
        logic signed [16:0] e;
        e = 17'(x);
        return (e < 0) ? 17'(-e) : 17'(e);
    endfunction

endpackage

// File: rtl/cfr_delay.sv
module cfr_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) st[k] <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
        end
    end

    assign q = st[DEPTH-1];
endmodule

// File: rtl/cfr_regs.sv
module cfr_regs
    import peakwin_pkg::*;
#(
    parameter int MAX_ORD = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic [CW-1:0] coef [MAX_ORD+1],
    output logic [7:0]    order,
    output logic [CW-1:0] thr,
    output logic [GW-1:0] gain,
    output logic          bypass,
    output logic          interp
);
    localparam int TAPS = MAX_ORD + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS; j++) coef[j] <= '0;
            order  <= 8'd1;
            thr    <= ONE_Q15;
            gain   <= GAIN_ONE;
            bypass <= 1'b0;
            interp <= 1'b0;
        end else if (we) begin
            for (int j = 0; j < TAPS; j++) begin
                if (int'(addr) == j) coef[j] <= wdata;
            end
            case (addr)
                A_ORDER: order <= wdata[7:0];
                A_THR:   thr   <= wdata;
                A_GAIN:  gain  <= wdata;
                A_FLAGS: begin
                    bypass <= wdata[0];
                    interp <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < TAPS; j++) begin
            if (int'(addr) == j) rdata = coef[j];
        end
        case (addr)
            A_ORDER: rdata = {8'd0, order};
            A_THR:   rdata = thr;
            A_GAIN:  rdata = gain;
            A_FLAGS: rdata = {14'd0, interp, bypass};
            default: ;
        endcase
    end

    // R9
    thr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_THR) |=> (thr == $past(wdata)));

    // R9
    gain_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_GAIN) |=> (gain == $past(wdata)));
endmodule

// File: rtl/cfr_weight.sv
module cfr_weight
    import peakwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  iq_t           in_s,
    input  logic [CW-1:0] thr,
    output logic [CW-1:0] w_q
);
    logic [15:0] rlut [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        localparam longint unsigned RV =
            (64'd1 << (17 + LUT_BITS)) / (64'(1 << (LUT_BITS + 1)) + 64'd1 + 64'(2 * g));
        assign rlut[g] = 16'(RV);
    end

    // stage 1: capture
    iq_t r1;
    always_ff @(posedge clk) begin
        if (rst) r1 <= '0;
        else     r1 <= in_s;
    end

    // stage 2: power test and magnitude estimate
    logic [16:0] ai, aq, mx, mn;
    logic [17:0] alt, mest;
    logic [33:0] mag2, thr2;
    logic        exc_d;
    logic [15:0] m_q;
    logic        exc_q;

    always_comb begin
        ai    = abs17(r1.i);
        aq    = abs17(r1.q);
        mx    = (ai > aq) ? ai : aq;
        mn    = (ai > aq) ? aq : ai;
        alt   = 18'(mx) - 18'(mx >> 3) + 18'(mn >> 1);
        mest  = (alt > 18'(mx)) ? alt : 18'(mx);
        mag2  = 34'(ai) * 34'(ai) + 34'(aq) * 34'(aq);
        thr2  = 34'(thr) * 34'(thr);
        exc_d = r1.valid && (thr < ONE_Q15) && (mag2 > thr2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= '0;
            exc_q <= 1'b0;
        end else begin
            m_q   <= 16'(mest);
            exc_q <= exc_d;
        end
    end

    // stage 3: weight = 1 - T/m through normalised reciprocal
    logic [3:0]          lp;
    logic [15:0]         norm;
    logic [LUT_BITS-1:0] kidx;
    logic [31:0]         tr, ratio;
    logic [CW-1:0]       w_d;

    always_comb begin
        lp    = lead_one(m_q);
        norm  = m_q << (4'd15 - lp);
        kidx  = norm[14 -: LUT_BITS];
        tr    = 32'(thr) * 32'(rlut[kidx]);
        ratio = tr >> (5'(lp) + 5'd1);
        if (exc_q && ratio < 32'(ONE_Q15)) w_d = CW'(32'(ONE_Q15) - ratio);
        else                               w_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) w_q <= '0;
        else     w_q <= w_d;
    end

    // R5
    weight_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (w_q != '0) |-> $past(exc_q));

    // R5
    weight_range_chk: assert property (@(posedge clk) disable iff (rst)
        (w_q <= ONE_Q15));
endmodule

// File: rtl/cfr_window.sv
module cfr_window
    import peakwin_pkg::*;
#(
    parameter int MAX_ORD = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] w_in,
    input  logic [CW-1:0] coef [MAX_ORD+1],
    input  logic [7:0]    eff_ord,
    output logic [CW-1:0] s_q
);
    localparam int TAPS = MAX_ORD + 1;
    localparam int HALF = MAX_ORD / 2;
    localparam int IW   = $clog2(TAPS);

    logic [CW-1:0] wdl  [MAX_ORD];
    logic [CW-1:0] wtap [TAPS];
    logic [CW-1:0] pc   [TAPS];
    logic [CW-1:0] prod_q [TAPS];
    logic [7:0]    off;
    logic [CW-1:0] smax;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < MAX_ORD; d++) wdl[d] <= '0;
        end else begin
            wdl[0] <= w_in;
            for (int d = 1; d < MAX_ORD; d++) wdl[d] <= wdl[d-1];
        end
    end

    always_comb begin
        wtap[0] = w_in;
        for (int d = 1; d < TAPS; d++) wtap[d] = wdl[d-1];
    end

    // position p sees coefficient index p - off, centred on the data delay HALF
    always_comb begin
        off = 8'(HALF) - (eff_ord >> 1);
        for (int p = 0; p < TAPS; p++) begin
            logic [7:0]    rel;
            logic          act;
            logic [CW-1:0] h;
            logic [31:0]   pr;
            rel = 8'(p) - off;
            act = (8'(p) >= off) && (rel <= eff_ord);
            h   = act ? coef[IW'(rel)] : '0;
            pr  = (32'(wtap[p]) * 32'(h)) >> QF;
            pc[p] = (pr > 32'(ONE_Q15)) ? ONE_Q15 : CW'(pr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < TAPS; p++) prod_q[p] <= '0;
        end else begin
            for (int p = 0; p < TAPS; p++) prod_q[p] <= pc[p];
        end
    end

    always_comb begin
        smax = '0;
        for (int p = 0; p < TAPS; p++) begin
            if (prod_q[p] > smax) smax = prod_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= smax;
    end

    // R7
    centre_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q >= $past(prod_q[HALF])));
endmodule

// File: rtl/peakwin_cfr.sv
module peakwin_cfr
    import peakwin_pkg::*;
#(
    parameter int MAX_ORD = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [15:0]          cfg_wdata,
    output logic [15:0]          cfg_rdata,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    localparam int HALF  = MAX_ORD / 2;
    localparam int DDLY  = HALF + 5;

    logic [CW-1:0] coef [MAX_ORD+1];
    logic [7:0]    ord_r, eff_ord, lim;
    logic [CW-1:0] thr_r;
    logic [GW-1:0] gain_r;
    logic          byp_r, intp_r;

    cfr_regs #(.MAX_ORD(MAX_ORD)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .coef(coef), .order(ord_r), .thr(thr_r),
        .gain(gain_r), .bypass(byp_r), .interp(intp_r)
    );

    always_comb begin
        lim = intp_r ? 8'(HALF) : 8'(MAX_ORD);
        if (ord_r == 8'd0)    eff_ord = 8'd1;
        else if (ord_r > lim) eff_ord = lim;
        else                  eff_ord = ord_r;
    end

    iq_t in_s;
    always_comb begin
        in_s.valid = in_valid;
        in_s.i     = in_valid ? in_i : '0;
        in_s.q     = in_valid ? in_q : '0;
    end

    logic [CW-1:0] w_s, s_w;

    cfr_weight u_weight (
        .clk(clk), .rst(rst), .in_s(in_s), .thr(thr_r), .w_q(w_s)
    );

    cfr_window #(.MAX_ORD(MAX_ORD)) u_window (
        .clk(clk), .rst(rst), .w_in(w_s), .coef(coef), .eff_ord(eff_ord), .s_q(s_w)
    );

    logic [IQW-1:0] dly_bits;
    iq_t            dly;

    cfr_delay #(.W(IQW), .DEPTH(DDLY)) u_dly (
        .clk(clk), .rst(rst), .d(in_s), .q(dly_bits)
    );
    assign dly = iq_t'(dly_bits);

    // scale stage
    logic [16:0]        gfac;
    logic signed [33:0] pi, pq;
    iq_t                sc_q, raw_q;

    always_comb begin
        gfac = 17'(ONE_Q15) - 17'(s_w);
        pi   = 34'(dly.i) * 34'(signed'({1'b0, gfac}));
        pq   = 34'(dly.q) * 34'(signed'({1'b0, gfac}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q  <= '0;
            raw_q <= '0;
        end else begin
            sc_q.valid <= dly.valid;
            sc_q.i     <= SW'(pi >>> QF);
            sc_q.q     <= SW'(pq >>> QF);
            raw_q      <= dly;
        end
    end

    // gain stage
    logic signed [33:0] gi, gq;
    always_comb begin
        gi = 34'(sc_q.i) * 34'(signed'({1'b0, gain_r}));
        gq = 34'(sc_q.q) * 34'(signed'({1'b0, gain_r}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= sc_q.valid;
            out_i     <= byp_r ? raw_q.i : sat_s16(gi >>> GFRAC);
            out_q     <= byp_r ? raw_q.q : sat_s16(gq >>> GFRAC);
        end
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_i == '0 && out_q == '0));

    // R6
    unity_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (dly.valid && s_w == '0) |=> (sc_q.i == $past(dly.i) && sc_q.q == $past(dly.q)));

    // R8
    order_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_ord != 8'd0) && (!intp_r || eff_ord <= 8'(HALF)));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (byp_r && $past(byp_r)) |-> (out_i == $past(raw_q.i) && out_q == $past(raw_q.q)));
endmodule

// File: tb/peakwin_cfr_test.sv
module peakwin_cfr_test;

    localparam int MAXO = 40;
    localparam int LAT  = MAXO / 2 + 7;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic               cfg_we = 1'b0;
    logic [6:0]         cfg_addr = '0;
    logic [15:0]        cfg_wdata = '0;
    logic [15:0]        cfg_rdata;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    peakwin_cfr #(.MAX_ORD(MAXO)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    int total = 0, fails = 0;
    bit done = 0;

    logic signed [15:0] bi [64], bq [64];
    logic               bv [64];
    logic signed [15:0] oi [64], oq [64];
    int nout, first;

    typedef struct packed {
        logic signed [15:0] i;
        logic signed [15:0] q;
        logic [15:0]        g;
    } vec_t;

    localparam vec_t VT [9] = '{
        '{16'sd1000,   -16'sd2000,  16'd16384},
        '{16'sd32767,  -16'sd32768, 16'd16384},
        '{16'sd20000,  -16'sd20000, 16'd32768},
        '{-16'sd3,     16'sd5,      16'd8192},
        '{16'sd12345,  16'sd4321,   16'd65535},
        '{-16'sd100,   16'sd100,    16'd0},
        '{16'sd7,      -16'sd7,     16'd24576},
        '{16'sd30000,  16'sd30000,  16'd16384},
        '{16'sd0,      16'sd0,      16'd16384}
    };

    function automatic int exp_gain(input int x, input int g);
        longint v;
        v = (longint'(x) * longint'(g)) >>> 14;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output int v);
        @(negedge clk);
        cfg_addr = a;
        #1;
        v = int'(cfg_rdata);
    endtask

    task automatic run(input int n);
        nout = 0; first = -1;
        for (int c = 0; c < n + LAT + MAXO + 6; c++) begin
            @(negedge clk);
            if (out_valid) begin
                if (first < 0) first = c;
                if (nout < 64) begin
                    oi[nout] = out_i; oq[nout] = out_q;
                end
                nout++;
            end
            if (c < n) begin
                in_valid = bv[c]; in_i = bi[c]; in_q = bq[c];
            end else begin
                in_valid = 1'b0; in_i = '0; in_q = '0;
            end
        end
    endtask

    task automatic fill_peak(input int n, input int pk);
        for (int k = 0; k < n; k++) begin
            bv[k] = 1'b1; bi[k] = 16'sd1000; bq[k] = 16'sd0;
        end
        bi[pk] = 16'sd30000;
    endtask

    task automatic set_coefs(input int lo, input int hi, input logic [15:0] v);
        for (int j = lo; j <= hi; j++) wr(7'(j), v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        #1;
        // R9 / R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid during reset", int'(out_valid), 0);
        @(negedge clk); rst = 1'b0;
        check(out_i == 0 && out_q == 0, "R1", "output after reset", int'(out_i), 0);
        rd(7'h40, v); check(v == 1,     "R9", "order reset",     v, 1);
        rd(7'h41, v); check(v == 32768, "R9", "threshold reset", v, 32768);
        rd(7'h42, v); check(v == 16384, "R9", "gain reset",      v, 16384);
        rd(7'h43, v); check(v == 0,     "R9", "flags reset",     v, 0);
        rd(7'd5,  v); check(v == 0,     "R9", "coef reset",      v, 0);

        // R2 / R3 table walk, clipping disabled by threshold 1.0
        foreach (VT[t]) begin
            wr(7'h42, VT[t].g);
            bv[0] = 1'b1; bi[0] = VT[t].i; bq[0] = VT[t].q;
            run(1);
            check(nout == 1, "R1", "table output count", nout, 1);
            check(int'(oi[0]) == exp_gain(int'(VT[t].i), int'(VT[t].g)), "R3", "table I",
                  int'(oi[0]), exp_gain(int'(VT[t].i), int'(VT[t].g)));
            check(int'(oq[0]) == exp_gain(int'(VT[t].q), int'(VT[t].g)), "R2", "table Q",
                  int'(oq[0]), exp_gain(int'(VT[t].q), int'(VT[t].g)));
            if (t == 0) check(first == LAT, "R1", "latency", first, LAT);
        end

        // R2 threshold above 1.0 still disables clipping
        wr(7'h42, 16'd16384); wr(7'h41, 16'd50000);
        set_coefs(0, MAXO, 16'd32768); wr(7'h40, 16'd4);
        fill_peak(21, 10);
        run(21);
        check(int'(oi[10]) == 30000, "R2", "threshold 50000 peak", int'(oi[10]), 30000);
        check(int'(oi[9]) == 1000,   "R2", "threshold 50000 neighbour", int'(oi[9]), 1000);

        // R1 invalid samples produce nothing
        for (int k = 0; k < 5; k++) begin bv[k] = 1'b0; bi[k] = 16'sd777; bq[k] = -16'sd5; end
        run(5);
        check(nout == 0, "R1", "invalid samples", nout, 0);
        bv[0] = 1'b1; bi[0] = 16'sd11; bq[0] = 16'sd12;
        bv[1] = 1'b0; bi[1] = 16'sd99; bq[1] = 16'sd99;
        bv[2] = 1'b1; bi[2] = 16'sd13; bq[2] = 16'sd14;
        run(3);
        check(nout == 2, "R1", "gapped valid count", nout, 2);
        check(int'(oi[1]) == 13 && int'(oq[1]) == 14, "R1", "gapped second sample", int'(oi[1]), 13);

        // R5 / R6 / R7 rectangular window, order 4
        set_coefs(0, MAXO, 16'd0);
        set_coefs(0, 4, 16'd32768);
        wr(7'h41, 16'd16384);
        fill_peak(21, 10);
        run(21);
        v = int'(oi[10]) * int'(oi[10]) + int'(oq[10]) * int'(oq[10]);
        check(v >= 14745 * 14745 && v <= 17694 * 17694, "R5", "peak magnitude squared",
              v, 16384 * 16384);
        check(oi[8] < 1000 && oi[12] < 1000, "R7", "rect edge reduced", int'(oi[8]), 1000);
        check(oi[9] < 1000 && oi[11] < 1000, "R7", "rect inner reduced", int'(oi[11]), 1000);
        check(oi[7] == 1000 && oi[13] == 1000, "R7", "outside span", int'(oi[13]), 1000);
        check(oi[0] == 1000 && oq[0] == 0, "R6", "far sample unchanged", int'(oi[0]), 1000);

        // R7 tapered window: zero end taps leave edge samples alone
        set_coefs(0, 0, 16'd0); set_coefs(1, 1, 16'd16384);
        set_coefs(3, 3, 16'd16384); set_coefs(4, 4, 16'd0);
        run(21);
        check(oi[8] == 1000 && oi[12] == 1000, "R7", "zero taps", int'(oi[8]), 1000);
        check(oi[9] < 1000 && oi[11] < 1000, "R7", "half taps", int'(oi[9]), 1000);

        // R7 coefficient direction: only index 0 set, affects t = -2
        set_coefs(0, 4, 16'd0); set_coefs(0, 0, 16'd32768);
        run(21);
        check(oi[10] == 30000, "R7", "centre tap zero keeps peak", int'(oi[10]), 30000);
        check(oi[8] < 1000, "R7", "index 0 hits t=-2", int'(oi[8]), 1000);
        check(oi[12] == 1000 && oi[9] == 1000, "R7", "other side untouched", int'(oi[12]), 1000);

        // R8 order 0 acts as 1: span t = 0..1
        set_coefs(0, MAXO, 16'd32768); wr(7'h40, 16'd0);
        run(21);
        check(oi[9] == 1000 && oi[12] == 1000, "R8", "order 0 outside", int'(oi[9]), 1000);
        check(oi[11] < 1000, "R8", "order 0 acts as 1", int'(oi[11]), 1000);

        // R8 doubled-rate cap: order 30 -> 20, span -10..10
        wr(7'h40, 16'd30); wr(7'h43, 16'd2);
        fill_peak(32, 15);
        run(32);
        check(oi[5] < 1000 && oi[25] < 1000, "R8", "interp span edge", int'(oi[25]), 1000);
        check(oi[4] == 1000 && oi[26] == 1000, "R8", "interp cap", int'(oi[26]), 1000);

        // R8 base mode: order 30 used as is, span -15..15
        wr(7'h43, 16'd0);
        run(32);
        check(oi[30] < 1000, "R8", "base order 30 edge", int'(oi[30]), 1000);
        check(oi[31] == 1000, "R8", "base order 30 outside", int'(oi[31]), 1000);

        // R8 base cap: order 60 -> 40, span -20..20
        wr(7'h40, 16'd60);
        fill_peak(50, 25);
        run(50);
        check(oi[5] < 1000 && oi[45] < 1000, "R8", "base cap edge", int'(oi[45]), 1000);
        check(oi[4] == 1000 && oi[46] == 1000, "R8", "base cap outside", int'(oi[46]), 1000);

        // R4 pass-through ignores clipping and gain
        wr(7'h40, 16'd4); wr(7'h42, 16'd32768); wr(7'h43, 16'd1);
        fill_peak(21, 10); bq[10] = -16'sd5;
        run(21);
        check(oi[10] == 30000 && oq[10] == -5, "R4", "bypass peak", int'(oi[10]), 30000);
        check(oi[9] == 1000, "R4", "bypass no gain", int'(oi[9]), 1000);
        check(first == LAT, "R4", "bypass latency", first, LAT);

        // R9 readback
        wr(7'd3, 16'h1234);
        rd(7'd3,  v); check(v == 16'h1234, "R9", "coef readback", v, 16'h1234);
        rd(7'h43, v); check(v == 1, "R9", "flags readback", v, 1);
        rd(7'h40, v); check(v == 4, "R9", "order readback", v, 4);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule